// File: doc/BRIEF.md
# Fractional-Compensated Serial Baud Generator

This block makes the timing references for a serial port. In asynchronous mode it emits a sample tick at 16 times the bit rate, or 8 times in double-speed mode. It also emits a bit tick once per bit. In synchronous or SPI master mode it produces a square-wave serial clock instead.

The rate comes from an 8-bit integer divisor. The divisor is programmed as the ideal value rounded up, so the raw rate is slightly slow. An optional 8-bit fractional correction then removes that error. On every sample tick the fraction is added into an 8-bit accumulator. Each carry out of that sum removes one system clock from the next period. The average period becomes (divisor + 1 − fraction/256) system clocks.

The surrounding logic pulses a configuration strobe whenever it writes new divisor or fraction values. The strobe restarts the generator from a known phase. Divisor values that are illegal for the current mode are raised to the smallest legal value.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, `sampleTick`, `bitTick` and `sclk` are all 0.
- R2: In asynchronous mode (`mode` = 2'b00) with `compEn` low, `sampleTick` pulses for one cycle every (D + 1) system clocks, where D is the effective divisor.
- R3: In asynchronous mode with `compEn` high, the fraction F is added modulo 256 into an accumulator on each sample tick. A carry out shortens the following period to D clocks. Over 32 consecutive periods after a restart, the total is 32·(D+1) − floor(32·F/256) clocks.
- R4: With `dblSpeed` low, `bitTick` is high together with every 16th `sampleTick` after a restart, and at no other time.
- R5: With `dblSpeed` high in asynchronous mode, `bitTick` is high together with every 8th `sampleTick` after a restart.
- R6: In synchronous (2'b01) or SPI (2'b10, and 2'b11 treated as SPI) mode, `sampleTick` and `bitTick` stay 0. `sclk` toggles once every (D + 1) system clocks while `sclkEn` is high. `compEn` and `dblSpeed` have no effect in these modes.
- R7: In synchronous or SPI mode, `sclk` holds its level while `sclkEn` is low.
- R8: The effective divisor D is `divisor` raised to at least 1 in asynchronous mode, and to at least 2 in synchronous or SPI mode.
- R9: A `cfgWr` pulse clears the accumulator, the bit prescaler and `sclk`, and reloads the counter with D. The first expiry then falls exactly D cycles after the edge that captured the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 8 | Integer divisor value |
| fraction | input | 8 | Fractional correction value |
| cfgWr | input | 1 | One-cycle strobe marking a write of divisor or fraction |
| compEn | input | 1 | Enables fractional compensation in asynchronous mode |
| dblSpeed | input | 1 | Selects 8x instead of 16x oversampling |
| mode | input | 2 | 00 async, 01 sync, 10/11 SPI master |
| sclkEn | input | 1 | Requests serial clock activity (transmit data loaded) |
| sampleTick | output | 1 | Oversampling tick, one cycle wide |
| bitTick | output | 1 | Bit-rate tick, one cycle wide |
| sclk | output | 1 | Serial clock for synchronous and SPI modes |

## Verification
The bench measures the exact length of 32 periods after a restart, using fractions whose carry count over 32 ticks is known. A generator that applied the carry to the wrong period, or that never dropped a cycle, would miss the expected total by several clocks. Divisors of 0 and 1 are driven in every mode. A missing clamp would show up as a stalled or far too fast tick or clock. The bench also checks that the first tick after a configuration write lands exactly D cycles later, and that `sclk` stays frozen while `sclkEn` is low. It checks that fraction and double-speed settings leave the serial clock period unchanged.

// File: rtl/fbaud_pkg.sv
package fbaud_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC   = 2'b00,
    MODE_SYNC    = 2'b01,
    MODE_SPI     = 2'b10,
    MODE_SPI_ALT = 2'b11
  } serMode_e;

  typedef struct packed {
    logic restart;
    logic asyncMode;
    logic compOn;
    logic dblOn;
    logic sclkRun;
  } dpCtrl_t;

endpackage

// File: rtl/fbaud_ctrl.sv
module fbaud_ctrl
  import fbaud_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] rawDiv,
  input  logic [1:0]       modeSel,
  input  logic             compEn,
  input  logic             dblSpeed,
  input  logic             cfgWr,
  input  logic             sclkEn,
  output dpCtrl_t          ctrl,
  output logic [DIV_W-1:0] effDiv
);

  localparam logic [DIV_W-1:0] MIN_ASYNC = DIV_W'(1);
  localparam logic [DIV_W-1:0] MIN_CLKED = DIV_W'(2);

  serMode_e         curMode;
  logic             isAsync;
  logic [DIV_W-1:0] minDiv;

  always_comb begin
    curMode = serMode_e'(modeSel);
    isAsync = (curMode == MODE_ASYNC);
    // R8: smallest legal divisor depends on mode
    minDiv  = isAsync ? MIN_ASYNC : MIN_CLKED;
    effDiv  = (rawDiv < minDiv) ? minDiv : rawDiv;
  end

  always_comb begin
    ctrl.restart   = cfgWr;
    ctrl.asyncMode = isAsync;
    ctrl.compOn    = isAsync & compEn;   // R6: compensation ignored when clocked
    ctrl.dblOn     = isAsync & dblSpeed; // R6: double speed ignored when clocked
    ctrl.sclkRun   = ~isAsync & sclkEn;
  end

endmodule

// File: rtl/fbaud_datapath.sv
module fbaud_datapath
  import fbaud_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DIV_W-1:0]  effDiv,
  input  logic [FRAC_W-1:0] frac,
  output logic              sampleTick,
  output logic              bitTick,
  output logic              sclk
);

  localparam int PW = $clog2(OVS);

  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W-1:0] accNext;
  logic              carry;
  logic              useCarry;
  logic [DIV_W-1:0]  reload;
  logic [PW-1:0]     pre;
  logic              sclkQ;
  logic              expire;
  logic              preFull;

  always_comb begin
    expire           = (cnt == '0);
    {carry, accNext} = {1'b0, acc} + {1'b0, frac};
    useCarry         = ctrl.compOn & carry;
    // R3: a carry drops one clock from the period starting now
    reload           = effDiv - DIV_W'(useCarry);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '1;
      acc   <= '0;
      pre   <= '0;
      sclkQ <= 1'b0;
    end else if (ctrl.restart) begin
      // R9: clean phase after a configuration write
      cnt   <= effDiv;
      acc   <= '0;
      pre   <= '0;
      sclkQ <= 1'b0;
    end else if (expire) begin
      cnt <= reload;
      if (ctrl.compOn)    acc   <= accNext;
      if (ctrl.asyncMode) pre   <= pre + PW'(1);
      if (ctrl.sclkRun)   sclkQ <= ~sclkQ;
    end else begin
      cnt <= cnt - DIV_W'(1);
    end
  end

  generate
    if (PW > 1) begin : g_half
      assign preFull = ctrl.dblOn ? (&pre[PW-2:0]) : (&pre);
    end else begin : g_single
      assign preFull = ctrl.dblOn ? 1'b1 : (&pre);
    end
  endgenerate

  assign sampleTick = expire & ctrl.asyncMode & rstN;
  assign bitTick    = sampleTick & preFull;
  assign sclk       = sclkQ;

  p_reload_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctrl.restart) |=>
      (cnt == $past(effDiv) || cnt == $past(effDiv) - DIV_W'(1)));

  p_clocked_no_ticks_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.asyncMode |-> (!sampleTick && !bitTick));

  p_bit_on_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);

  p_sclk_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.sclkRun && !ctrl.restart) |=> $stable(sclkQ));

  p_restart_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restart |=> (cnt == $past(effDiv) && acc == '0 && !sclkQ));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbaud_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] fraction,
  input  logic              cfgWr,
  input  logic              compEn,
  input  logic              dblSpeed,
  input  logic [1:0]        mode,
  input  logic              sclkEn,
  output logic              sampleTick,
  output logic              bitTick,
  output logic              sclk
);

  dpCtrl_t          ctrl;
  logic [DIV_W-1:0] effDiv;

  fbaud_ctrl #(.DIV_W(DIV_W)) i_ctrl (
    .rawDiv   (divisor),
    .modeSel  (mode),
    .compEn   (compEn),
    .dblSpeed (dblSpeed),
    .cfgWr    (cfgWr),
    .sclkEn   (sclkEn),
    .ctrl     (ctrl),
    .effDiv   (effDiv)
  );

  fbaud_datapath #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OVS(OVS)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .effDiv     (effDiv),
    .frac       (fraction),
    .sampleTick (sampleTick),
    .bitTick    (bitTick),
    .sclk       (sclk)
  );

endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic [7:0] fraction = 8'd0;
  logic       cfgWr = 1'b0;
  logic       compEn = 1'b0;
  logic       dblSpeed = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       sclkEn = 1'b0;
  logic       sampleTick, bitTick, sclk;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rstN(rstN), .divisor(divisor), .fraction(fraction),
    .cfgWr(cfgWr), .compEn(compEn), .dblSpeed(dblSpeed), .mode(mode),
    .sclkEn(sclkEn), .sampleTick(sampleTick), .bitTick(bitTick), .sclk(sclk)
  );

  typedef struct packed {
    logic [7:0]  div;
    logic [7:0]  frac;
    logic        comp;
    logic        dbl;
    logic [1:0]  md;
    logic [15:0] expCyc;
    logic [3:0]  expBits;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd104, 8'd213, 1'b1, 1'b0, 2'b00, 16'd3334, 4'd2, 4'd3}, // R3 9600 case
    '{8'd104, 8'd213, 1'b0, 1'b0, 2'b00, 16'd3360, 4'd2, 4'd2}, // R2 no comp
    '{8'd8,   8'd82,  1'b1, 1'b0, 2'b00, 16'd278,  4'd2, 4'd4}, // R4 115200 case
    '{8'd8,   8'd82,  1'b1, 1'b1, 2'b00, 16'd278,  4'd4, 4'd5}, // R5 double speed
    '{8'd0,   8'd0,   1'b0, 1'b0, 2'b00, 16'd64,   4'd2, 4'd8}, // R8 async clamp
    '{8'd1,   8'd200, 1'b1, 1'b0, 2'b01, 16'd96,   4'd0, 4'd8}, // R8 sync clamp
    '{8'd0,   8'd0,   1'b0, 1'b0, 2'b10, 16'd96,   4'd0, 4'd8}, // R8 SPI clamp
    '{8'd5,   8'd99,  1'b1, 1'b1, 2'b01, 16'd192,  4'd0, 4'd6}, // R6 ignores comp/dbl
    '{8'd255, 8'd255, 1'b1, 1'b0, 2'b00, 16'd8161, 4'd2, 4'd3}  // R3 max values
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseCfg();
    cfgWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    int events = 0;
    int cyc = 0;
    int bits = 0;
    int samples = 0;
    logic prevSclk;
    logic ev;
    logic isAsync;
    @(negedge clk);
    divisor = v.div; fraction = v.frac; compEn = v.comp;
    dblSpeed = v.dbl; mode = v.md; sclkEn = 1'b1;
    isAsync = (v.md == 2'b00);
    pulseCfg();
    prevSclk = sclk;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      ev = isAsync ? sampleTick : (sclk != prevSclk);
      prevSclk = sclk;
      if (sampleTick) samples++;
      if (events >= 1) cyc++;
      if (ev) begin
        events++;
        if (events >= 2 && bitTick) bits++;
        if (events == 33) break;
      end
    end
    check({reqName(v.req), " period total"}, cyc, int'(v.expCyc));
    check({reqName(v.req), " bit ticks"}, bits, int'(v.expBits));
    if (!isAsync) check("R6 no sample ticks in clocked mode", samples, 0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs low during reset
    repeat (3) @(negedge clk);
    check("R1 sampleTick in reset", int'(sampleTick), 0);
    check("R1 bitTick in reset", int'(bitTick), 0);
    check("R1 sclk in reset", int'(sclk), 0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // R9: first tick exactly D cycles after the capturing edge
    begin
      int when = -1;
      @(negedge clk);
      divisor = 8'd3; fraction = 8'd0; compEn = 1'b0; dblSpeed = 1'b0;
      mode = 2'b00; sclkEn = 1'b0;
      repeat (2) @(negedge clk);
      pulseCfg();
      for (int i = 1; i <= 10; i++) begin
        @(negedge clk);
        if (sampleTick && when < 0) when = i;
      end
      check("R9 first tick delay D=3", when, 3);
    end

    // R9: restart mid-period with new divisor
    begin
      int when = -1;
      divisor = 8'd7;
      pulseCfg();
      for (int i = 1; i <= 20; i++) begin
        @(negedge clk);
        if (sampleTick && when < 0) when = i;
      end
      check("R9 first tick delay D=7", when, 7);
    end

    // R7: sclk frozen while sclkEn low in sync mode
    begin
      int changes = 0;
      logic prev;
      divisor = 8'd2; mode = 2'b01; sclkEn = 1'b0;
      pulseCfg();
      prev = sclk;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (sclk != prev) changes++;
        prev = sclk;
      end
      check("R7 sclk changes with sclkEn low", changes, 0);
      // R6: toggling resumes when enabled, mode 2'b11 as SPI
      mode = 2'b11; sclkEn = 1'b1;
      pulseCfg();
      prev = sclk;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (sclk != prev) changes++;
        prev = sclk;
      end
      check("R6 sclk toggles in 30 cycles D=2", changes, 10);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule